// File: doc/BRIEF.md
# I2C Master Transfer Sequencer

This block runs one multi-byte I2C master transfer of one to four bytes each time software writes a control word. It does not drive the I2C wires. It issues start, send, receive and stop requests, one at a time, to a byte-level bus engine. The engine reports whether each request was acknowledged. The sequencer also reads bytes from, or writes bytes into, a four-entry data buffer that sits outside it.

The control word selects:
- the direction of the transfer,
- the byte count,
- whether the bus is kept between bytes (chaining),
- whether a stop is forced after every byte (repeated-start request).

A halt bit releases a bus that is still held. An error flag and a sticky abort flag record failed starts and refused bytes. A count output shows how many bytes completed. A level interrupt signals when a transfer completes or when a halt completes. Each of the two interrupt sources has its own enable, and both are also gated by a global enable.

Top module: `i2c_xfer_seq`

## Requirements
- R1: An accepted control write is stored with bit 0 (go) read back as 0. A control write that arrives while `busy_o` is high is ignored, so `ctrl_o` is unchanged and no extra bus activity follows.
- R2: When the go bit (bit 0) is written, bits 5:4 plus one gives the number of bytes moved. The bytes use buffer indices 0 upward. The target address is `mst_addr_i[7:1]`, and bit 1 selects a read (1) or a write (0).
- R3: Engine requests are encoded as op 0 start, 1 send, 2 receive and 3 stop. A request holds its op until it is acknowledged. A start is requested before a byte only when `bus_busy_i` is low. After each byte, a stop is requested when bit 3 is set or bit 2 is clear.
- R4: A start that returns `eng_nack_i` sets `err_o` and `abort_o` and ends the sequence with no further request (no stop).
- R5: An acknowledged start clears `err_o`. `abort_o` stays set until `abort_clr_i` is pulsed.
- R6: A written byte that returns `eng_nack_i` sets `err_o` and `abort_o` and ends the sequence.
- R7: During a read, each received byte is written into the buffer at that byte's index.
- R8: `xfer_cnt_o` equals the number of bytes completed by the last sequence.
- R9: When a sequence ends with at least one byte done, and both the global enable and the completion enable are high, `irq_o` rises. `irq_o` then holds until `irq_clr_i` is pulsed.
- R10: A write with bit 7 (halt) set while `bus_busy_i` is high requests a stop and starts no transfer, even if go is also set. When the stop completes, `irq_o` rises if both the global enable and the halt enable are high.
- R11: `busy_o` rises the cycle after an accepted go or halt write and falls when the sequence ends. No engine request is made while `busy_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ctrl_we_i | input | 1 | Control word write strobe |
| ctrl_wdata_i | input | 8 | Control word write data |
| ctrl_o | output | 8 | Stored control word |
| mst_addr_i | input | 8 | Master address register; bits 7:1 are the target |
| irq_glb_en_i | input | 1 | Global interrupt enable |
| irq_done_en_i | input | 1 | Completion interrupt enable |
| irq_halt_en_i | input | 1 | Halt interrupt enable |
| irq_clr_i | input | 1 | Clears the pending interrupt |
| abort_clr_i | input | 1 | Clears the abort flag |
| bus_busy_i | input | 1 | Bus currently held by this master |
| eng_req_o | output | 1 | Engine request valid |
| eng_op_o | output | 2 | Engine op: 0 start, 1 send, 2 receive, 3 stop |
| eng_addr_o | output | 7 | Target address for a start |
| eng_rd_o | output | 1 | Direction for a start, 1 = read |
| eng_wdata_o | output | 8 | Byte to send |
| eng_ack_i | input | 1 | Engine completion pulse |
| eng_nack_i | input | 1 | Target refused, valid with eng_ack_i |
| eng_rdata_i | input | 8 | Received byte, valid with eng_ack_i |
| buf_idx_o | output | 2 | Buffer index of the current byte |
| buf_rdata_i | input | 8 | Buffer byte at buf_idx_o |
| buf_we_o | output | 1 | Buffer write strobe |
| buf_wdata_o | output | 8 | Buffer write data |
| busy_o | output | 1 | Sequence in progress |
| err_o | output | 1 | Error flag |
| abort_o | output | 1 | Sticky transfer-abort flag |
| xfer_cnt_o | output | 3 | Bytes completed |
| irq_o | output | 1 | Interrupt request |

## Verification
Go and halt can be requested in the same control word, and which one acts depends only on whether the bus is held at that moment. The bench first leaves the bus held after a chained write and then writes halt and go together. It expects exactly one stop, no byte, the halt interrupt, and an unchanged byte count. It then writes the same word on a free bus and expects the halt bit to be stored while a normal one-byte transfer with its stop runs.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;
  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_SEND  = 2'd1,
    OP_RECV  = 2'd2,
    OP_STOP  = 2'd3
  } eng_op_e;

  typedef enum logic [2:0] {
    S_IDLE, S_CHECK, S_START, S_BYTE, S_STOP, S_NEXT, S_FIN, S_HALT
  } seq_state_e;

  localparam int CB_GO     = 0;
  localparam int CB_RD     = 1;
  localparam int CB_CHAIN  = 2;
  localparam int CB_RSTART = 3;
  localparam int CB_CNT_LO = 4;
  localparam int CB_CNT_HI = 5;
  localparam int CB_WIDE   = 6;
  localparam int CB_HALT   = 7;
endpackage

// File: rtl/i2c_seq_ctrl_reg.sv
module i2c_seq_ctrl_reg #(
  parameter int CTRL_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [CTRL_W-1:0] wdata_i,
  output logic [CTRL_W-1:0] ctrl_o
);
  import i2c_seq_pkg::*;

  logic [CTRL_W-1:0] ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else if (load_i) begin
      ctrl_q         <= wdata_i;
      ctrl_q[CB_GO]  <= 1'b0;  // go is a trigger, never held
    end
  end

  assign ctrl_o = ctrl_q;
endmodule

// File: rtl/i2c_seq_fsm.sv
module i2c_seq_fsm #(
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 7,
  parameter int BUF_DEPTH = 4,
  parameter int CTRL_W    = 8,
  localparam int IDX_W    = $clog2(BUF_DEPTH),
  localparam int CNT_W    = IDX_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_we_i,
  input  logic [CTRL_W-1:0] ctrl_wdata_i,
  input  logic [ADDR_W:0]   mst_addr_i,
  input  logic              bus_busy_i,
  output logic              load_o,
  output logic              eng_req_o,
  output logic [1:0]        eng_op_o,
  output logic [ADDR_W-1:0] eng_addr_o,
  output logic              eng_rd_o,
  output logic [DATA_W-1:0] eng_wdata_o,
  input  logic              eng_ack_i,
  input  logic              eng_nack_i,
  input  logic [DATA_W-1:0] eng_rdata_i,
  output logic [IDX_W-1:0]  buf_idx_o,
  input  logic [DATA_W-1:0] buf_rdata_i,
  output logic              buf_we_o,
  output logic [DATA_W-1:0] buf_wdata_o,
  output logic              busy_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              evt_start_ok_o,
  output logic              evt_fail_o,
  output logic              evt_done_o,
  output logic              evt_halt_o
);
  import i2c_seq_pkg::*;

  seq_state_e        st_q, st_d;
  logic [IDX_W-1:0]  idx_q, last_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] addr_q;
  logic              rd_q, stop_each_q;
  logic              idle, want_halt, want_go;

  assign idle      = (st_q == S_IDLE);
  assign load_o    = ctrl_we_i && idle;
  // halt outranks go only when the bus is actually held
  assign want_halt = load_o && ctrl_wdata_i[CB_HALT] && bus_busy_i;
  assign want_go   = load_o && ctrl_wdata_i[CB_GO] && !want_halt;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      S_IDLE:  if (want_halt) st_d = S_HALT;
               else if (want_go) st_d = S_CHECK;
      S_CHECK: st_d = bus_busy_i ? S_BYTE : S_START;
      S_START: if (eng_ack_i) st_d = eng_nack_i ? S_FIN : S_BYTE;
      S_BYTE:  if (eng_ack_i) begin
                 if (eng_nack_i && !rd_q) st_d = S_FIN;
                 else st_d = stop_each_q ? S_STOP : S_NEXT;
               end
      S_STOP:  if (eng_ack_i) st_d = S_NEXT;
      S_NEXT:  st_d = (idx_q == last_q) ? S_FIN : S_CHECK;
      S_FIN:   st_d = S_IDLE;
      S_HALT:  if (eng_ack_i) st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= S_IDLE;
      idx_q       <= '0;
      last_q      <= '0;
      cnt_q       <= '0;
      addr_q      <= '0;
      rd_q        <= 1'b0;
      stop_each_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (idle && want_go) begin
        idx_q       <= '0;
        last_q      <= ctrl_wdata_i[CB_CNT_HI:CB_CNT_LO];
        cnt_q       <= '0;
        addr_q      <= mst_addr_i[ADDR_W:1];
        rd_q        <= ctrl_wdata_i[CB_RD];
        stop_each_q <= ctrl_wdata_i[CB_RSTART] || !ctrl_wdata_i[CB_CHAIN];
      end
      if (st_q == S_BYTE && eng_ack_i && !(eng_nack_i && !rd_q))
        cnt_q <= cnt_q + CNT_W'(1);
      if (st_q == S_NEXT && idx_q != last_q)
        idx_q <= idx_q + IDX_W'(1);
    end
  end

  always_comb begin
    eng_op_o = OP_STOP;
    unique case (st_q)
      S_START: eng_op_o = OP_START;
      S_BYTE:  eng_op_o = rd_q ? OP_RECV : OP_SEND;
      default: eng_op_o = OP_STOP;
    endcase
  end

  assign eng_req_o      = (st_q == S_START) || (st_q == S_BYTE) ||
                          (st_q == S_STOP)  || (st_q == S_HALT);
  assign eng_addr_o     = addr_q;
  assign eng_rd_o       = rd_q;
  assign eng_wdata_o    = buf_rdata_i;
  assign buf_idx_o      = idx_q;
  assign buf_we_o       = (st_q == S_BYTE) && eng_ack_i && rd_q;
  assign buf_wdata_o    = eng_rdata_i;
  assign busy_o         = !idle;
  assign cnt_o          = cnt_q;
  assign evt_start_ok_o = (st_q == S_START) && eng_ack_i && !eng_nack_i;
  assign evt_fail_o     = eng_ack_i && eng_nack_i &&
                          ((st_q == S_START) || (st_q == S_BYTE && !rd_q));
  assign evt_done_o     = (st_q == S_FIN);
  assign evt_halt_o     = (st_q == S_HALT) && eng_ack_i;
endmodule

// File: rtl/i2c_seq_flags.sv
module i2c_seq_flags #(
  parameter int CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             evt_start_ok_i,
  input  logic             evt_fail_i,
  input  logic             evt_done_i,
  input  logic             evt_halt_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             irq_glb_en_i,
  input  logic             irq_done_en_i,
  input  logic             irq_halt_en_i,
  input  logic             irq_clr_i,
  input  logic             abort_clr_i,
  output logic             err_o,
  output logic             abort_o,
  output logic             irq_o
);
  logic err_q, abort_q, irq_q, irq_set;

  assign irq_set = irq_glb_en_i &&
                   ((evt_done_i && cnt_i != '0 && irq_done_en_i) ||
                    (evt_halt_i && irq_halt_en_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q   <= 1'b0;
      abort_q <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      if (evt_fail_i)          err_q <= 1'b1;
      else if (evt_start_ok_i) err_q <= 1'b0;
      if (evt_fail_i)          abort_q <= 1'b1;
      else if (abort_clr_i)    abort_q <= 1'b0;
      if (irq_set)             irq_q <= 1'b1;
      else if (irq_clr_i)      irq_q <= 1'b0;
    end
  end

  assign err_o   = err_q;
  assign abort_o = abort_q;
  assign irq_o   = irq_q;
endmodule

// File: rtl/i2c_xfer_seq.sv
module i2c_xfer_seq #(
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 7,
  parameter int BUF_DEPTH = 4,
  parameter int CTRL_W    = 8,
  localparam int IDX_W    = $clog2(BUF_DEPTH),
  localparam int CNT_W    = IDX_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_we_i,
  input  logic [CTRL_W-1:0] ctrl_wdata_i,
  output logic [CTRL_W-1:0] ctrl_o,
  input  logic [ADDR_W:0]   mst_addr_i,
  input  logic              irq_glb_en_i,
  input  logic              irq_done_en_i,
  input  logic              irq_halt_en_i,
  input  logic              irq_clr_i,
  input  logic              abort_clr_i,
  input  logic              bus_busy_i,
  output logic              eng_req_o,
  output logic [1:0]        eng_op_o,
  output logic [ADDR_W-1:0] eng_addr_o,
  output logic              eng_rd_o,
  output logic [DATA_W-1:0] eng_wdata_o,
  input  logic              eng_ack_i,
  input  logic              eng_nack_i,
  input  logic [DATA_W-1:0] eng_rdata_i,
  output logic [IDX_W-1:0]  buf_idx_o,
  input  logic [DATA_W-1:0] buf_rdata_i,
  output logic              buf_we_o,
  output logic [DATA_W-1:0] buf_wdata_o,
  output logic              busy_o,
  output logic              err_o,
  output logic              abort_o,
  output logic [CNT_W-1:0]  xfer_cnt_o,
  output logic              irq_o
);
  logic load, ev_ok, ev_fail, ev_done, ev_halt;

  i2c_seq_ctrl_reg #(.CTRL_W(CTRL_W)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .wdata_i (ctrl_wdata_i),
    .ctrl_o  (ctrl_o)
  );

  i2c_seq_fsm #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .BUF_DEPTH(BUF_DEPTH), .CTRL_W(CTRL_W)
  ) u_fsm (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .ctrl_we_i      (ctrl_we_i),
    .ctrl_wdata_i   (ctrl_wdata_i),
    .mst_addr_i     (mst_addr_i),
    .bus_busy_i     (bus_busy_i),
    .load_o         (load),
    .eng_req_o      (eng_req_o),
    .eng_op_o       (eng_op_o),
    .eng_addr_o     (eng_addr_o),
    .eng_rd_o       (eng_rd_o),
    .eng_wdata_o    (eng_wdata_o),
    .eng_ack_i      (eng_ack_i),
    .eng_nack_i     (eng_nack_i),
    .eng_rdata_i    (eng_rdata_i),
    .buf_idx_o      (buf_idx_o),
    .buf_rdata_i    (buf_rdata_i),
    .buf_we_o       (buf_we_o),
    .buf_wdata_o    (buf_wdata_o),
    .busy_o         (busy_o),
    .cnt_o          (xfer_cnt_o),
    .evt_start_ok_o (ev_ok),
    .evt_fail_o     (ev_fail),
    .evt_done_o     (ev_done),
    .evt_halt_o     (ev_halt)
  );

  i2c_seq_flags #(.CNT_W(CNT_W)) u_flags (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .evt_start_ok_i (ev_ok),
    .evt_fail_i     (ev_fail),
    .evt_done_i     (ev_done),
    .evt_halt_i     (ev_halt),
    .cnt_i          (xfer_cnt_o),
    .irq_glb_en_i   (irq_glb_en_i),
    .irq_done_en_i  (irq_done_en_i),
    .irq_halt_en_i  (irq_halt_en_i),
    .irq_clr_i      (irq_clr_i),
    .abort_clr_i    (abort_clr_i),
    .err_o          (err_o),
    .abort_o        (abort_o),
    .irq_o          (irq_o)
  );
endmodule

// File: rtl/i2c_xfer_seq_chk.sv
module i2c_xfer_seq_chk #(
  parameter int CTRL_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ctrl_we_i,
  input logic [CTRL_W-1:0] ctrl_o,
  input logic              bus_busy_i,
  input logic              eng_req_o,
  input logic [1:0]        eng_op_o,
  input logic              eng_ack_i,
  input logic              buf_we_o,
  input logic              busy_o,
  input logic              err_o,
  input logic              abort_o,
  input logic              irq_o
);
  assert_ignore_busy_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && ctrl_we_i) |=> $stable(ctrl_o));

  assert_op_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eng_req_o && !eng_ack_i) |=> (eng_req_o && $stable(eng_op_o)));

  assert_start_free_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(eng_req_o) && eng_op_o == 2'd0) |-> !bus_busy_i);

  assert_abort_err_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(abort_o) |-> err_o);

  assert_rx_in_seq_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_we_o |-> busy_o);

  assert_irq_from_seq_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(busy_o));

  assert_no_req_idle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !eng_req_o);
endmodule

bind i2c_xfer_seq i2c_xfer_seq_chk u_chk (.*);

// File: tb/i2c_xfer_seq_tb.sv
module i2c_xfer_seq_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk_i = 1'b0, rst_ni = 1'b0;
  logic       ctrl_we_i = 1'b0;
  logic [7:0] ctrl_wdata_i = '0, ctrl_o;
  logic [7:0] mst_addr_i = 8'hA4;
  logic       irq_glb_en_i = 1'b0, irq_done_en_i = 1'b0, irq_halt_en_i = 1'b0;
  logic       irq_clr_i = 1'b0, abort_clr_i = 1'b0;
  logic       bus_busy_i = 1'b0;
  logic       eng_req_o, eng_rd_o, buf_we_o, busy_o, err_o, abort_o, irq_o;
  logic [1:0] eng_op_o, buf_idx_o;
  logic [6:0] eng_addr_o;
  logic [7:0] eng_wdata_o, buf_wdata_o, buf_rdata_i;
  logic       eng_ack_i = 1'b0, eng_nack_i = 1'b0;
  logic [7:0] eng_rdata_i = '0;
  logic [2:0] xfer_cnt_o;

  int checks = 0, errors = 0;
  int n_start = 0, n_stop = 0, n_send = 0, n_recv = 0;
  logic [7:0] sent_log [64];
  logic [6:0] last_addr = '0;
  logic       last_rd = 1'b0;
  logic [7:0] tb_buf [4] = '{8'h11, 8'h22, 8'h33, 8'h44};
  logic       nack_start = 1'b0;
  int         nack_send_at = -1;
  logic       wait_c = 1'b0;

  i2c_xfer_seq u_dut (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;
  assign buf_rdata_i = tb_buf[buf_idx_o];

  always @(posedge clk_i) if (buf_we_o) tb_buf[buf_idx_o] <= buf_wdata_o;

  // byte engine and target model
  always @(negedge clk_i) begin
    if (eng_ack_i) begin
      eng_ack_i  <= 1'b0;
      eng_nack_i <= 1'b0;
    end else if (eng_req_o) begin
      if (!wait_c) wait_c <= 1'b1;
      else begin
        wait_c    <= 1'b0;
        eng_ack_i <= 1'b1;
        case (eng_op_o)
          2'd0: begin
            n_start   <= n_start + 1;
            last_addr <= eng_addr_o;
            last_rd   <= eng_rd_o;
            eng_nack_i <= nack_start;
            if (!nack_start) bus_busy_i <= 1'b1;
          end
          2'd1: begin
            sent_log[n_send % 64] <= eng_wdata_o;
            eng_nack_i <= (n_send == nack_send_at);
            n_send <= n_send + 1;
          end
          2'd2: begin
            eng_rdata_i <= 8'hA0 + 8'(n_recv);
            n_recv <= n_recv + 1;
          end
          default: begin
            n_stop <= n_stop + 1;
            bus_busy_i <= 1'b0;
          end
        endcase
      end
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic ctrl_write(input logic [7:0] v);
    @(negedge clk_i);
    ctrl_we_i = 1'b1; ctrl_wdata_i = v;
    @(negedge clk_i);
    ctrl_we_i = 1'b0;
  endtask

  task automatic run(input logic [7:0] v);
    ctrl_write(v);
    while (busy_o) @(negedge clk_i);
  endtask

  task automatic pulse_irq_clr();
    @(negedge clk_i); irq_clr_i = 1'b1;
    @(negedge clk_i); irq_clr_i = 1'b0;
  endtask

  task automatic t_reset();
    chk("R11", "busy after reset", busy_o, 0);
    chk("R8",  "count after reset", xfer_cnt_o, 0);
    chk("R1",  "ctrl after reset", ctrl_o, 0);
    chk("R9",  "irq after reset", irq_o, 0);
    chk("R4",  "err/abort after reset", {err_o, abort_o}, 0);
  endtask

  task automatic t_write3();
    int s0 = n_start, p0 = n_stop, d0 = n_send;
    irq_glb_en_i = 1'b1; irq_done_en_i = 1'b1;
    ctrl_write(8'h21);  // 3 bytes, write, no chain
    chk("R11", "busy after go", busy_o, 1);
    while (busy_o) @(negedge clk_i);
    chk("R3", "starts per byte", n_start - s0, 3);
    chk("R3", "stops per byte", n_stop - p0, 3);
    chk("R2", "bytes sent", n_send - d0, 3);
    for (int i = 0; i < 3; i++) chk("R2", "sent data order", sent_log[d0 + i], tb_buf[i]);
    chk("R2", "target address", last_addr, 7'h52);
    chk("R2", "write direction", last_rd, 0);
    chk("R8", "byte count", xfer_cnt_o, 3);
    chk("R1", "go bit reads 0", ctrl_o, 8'h20);
    chk("R9", "completion irq", irq_o, 1);
    pulse_irq_clr();
    chk("R9", "irq cleared", irq_o, 0);
  endtask

  task automatic t_chain_then_halt();
    int s0 = n_start, p0 = n_stop, d0 = n_send;
    irq_done_en_i = 1'b0; irq_halt_en_i = 1'b1;
    run(8'h35);  // 4 bytes, chained, no repeated start
    chk("R3", "chained single start", n_start - s0, 1);
    chk("R3", "chained no stop", n_stop - p0, 0);
    chk("R2", "chained four bytes", n_send - d0, 4);
    chk("R3", "bus kept", bus_busy_i, 1);
    chk("R9", "no irq with done disabled", irq_o, 0);
    d0 = n_send;
    run(8'h81);  // halt and go together on a held bus
    chk("R10", "halt stop", n_stop - p0, 1);
    chk("R10", "halt moves no byte", n_send - d0, 0);
    chk("R10", "halt irq", irq_o, 1);
    chk("R10", "count untouched", xfer_cnt_o, 4);
    pulse_irq_clr();
    d0 = n_send; p0 = n_stop;
    run(8'h81);  // same word on a free bus: transfer runs
    chk("R10", "free bus go runs", n_send - d0, 1);
    chk("R10", "free bus stop", n_stop - p0, 1);
    chk("R1", "halt bit stored", ctrl_o, 8'h80);
    chk("R10", "no halt irq", irq_o, 0);
    p0 = n_stop;
    ctrl_write(8'h80);
    repeat (4) @(negedge clk_i);
    chk("R11", "halt idle no busy", busy_o, 0);
    chk("R10", "halt idle no stop", n_stop - p0, 0);
  endtask

  task automatic t_rstart_read();
    int s0 = n_start, p0 = n_stop, r0 = n_recv;
    run(8'h3D);  // 4 bytes, chain + repeated start, write
    chk("R3", "rstart starts", n_start - s0, 4);
    chk("R3", "rstart stops", n_stop - p0, 4);
    s0 = n_start; p0 = n_stop;
    mst_addr_i = 8'h3F;
    run(8'h13);  // 2 bytes, read
    chk("R7", "rx byte 0", tb_buf[0], 8'hA0 + 8'(r0));
    chk("R7", "rx byte 1", tb_buf[1], 8'hA1 + 8'(r0));
    chk("R7", "byte 2 untouched", tb_buf[2], 8'h33);
    chk("R2", "read direction", last_rd, 1);
    chk("R2", "read address", last_addr, 7'h1F);
    chk("R8", "read count", xfer_cnt_o, 2);
  endtask

  task automatic t_start_nack();
    int p0 = n_stop, d0 = n_send;
    irq_done_en_i = 1'b1;
    nack_start = 1'b1;
    run(8'h11);
    nack_start = 1'b0;
    chk("R4", "err on start nack", err_o, 1);
    chk("R4", "abort on start nack", abort_o, 1);
    chk("R4", "no stop after failed start", n_stop - p0, 0);
    chk("R4", "no byte after failed start", n_send - d0, 0);
    chk("R8", "zero count", xfer_cnt_o, 0);
    chk("R9", "no irq on zero bytes", irq_o, 0);
    run(8'h01);
    chk("R5", "start ok clears err", err_o, 0);
    chk("R5", "abort sticky", abort_o, 1);
    @(negedge clk_i); abort_clr_i = 1'b1;
    @(negedge clk_i); abort_clr_i = 1'b0;
    chk("R5", "abort cleared", abort_o, 0);
    pulse_irq_clr();
  endtask

  task automatic t_send_nack();
    int p0, d0 = n_send;
    nack_send_at = n_send + 1;
    run(8'h21);
    nack_send_at = -1;
    chk("R6", "err on data nack", err_o, 1);
    chk("R6", "abort on data nack", abort_o, 1);
    chk("R6", "sequence ends", n_send - d0, 2);
    chk("R8", "one byte counted", xfer_cnt_o, 1);
    chk("R9", "irq after partial", irq_o, 1);
    pulse_irq_clr();
    irq_halt_en_i = 1'b0;
    p0 = n_stop;
    run(8'h80);
    chk("R10", "halt releases bus", n_stop - p0, 1);
    chk("R10", "halt irq disabled", irq_o, 0);
  endtask

  task automatic t_busy_write_and_glb();
    int d0 = n_send;
    irq_glb_en_i = 1'b0;
    ctrl_write(8'h31);
    repeat (2) @(negedge clk_i);
    ctrl_write(8'h07);
    chk("R1", "write while busy ignored", ctrl_o, 8'h30);
    while (busy_o) @(negedge clk_i);
    chk("R1", "no extra bytes", n_send - d0, 4);
    chk("R9", "global enable gates irq", irq_o, 0);
    chk("R11", "busy fell", busy_o, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_write3();
    t_chain_then_halt();
    t_rstart_read();
    t_start_nack();
    t_send_nack();
    t_busy_write_and_glb();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule